// File: doc/BRIEF.md
# Link Source Write Buffer with Flow Control

This block is the input stage on the transmit side of a point-to-point data link. User logic writes 32-bit words with a write enable, and each word carries a flag that marks it as data or as a link control word. The block queues each word for a serializer. The serializer takes at most one word for each slot it offers, and it offers a slot by pulsing a ready input. Control words such as fragment delimiters and check words move through the same queue. They use drain slots exactly as data words do, so short blocks fill the queue faster than the payload rate alone would suggest.

The block drives an active-low full flag back to the writer. The flag goes low when the queue comes near capacity or when the far end has requested a pause. A writer that is already committed may still push two more words after the flag drops. Any word beyond those two is discarded and raises a sticky overflow error. Words are accepted and drained only while the link is reported up. A status output for an indicator lamp mirrors the full condition.

Top module: `lsb_write_buffer`

## Requirements
- R1: After reset the queue is empty, `full_n_o` is 1, `xoff_led_o` is 0, `word_taken_o` is 0 and `ovf_err_o` is 0.
- R2: A write accepted while the link is up is stored in arrival order. All 32 data bits and the control flag (`wr_ctrl_i`, 1 = control word, 0 = data word) reach `rd_data_o` and `rd_ctrl_o` unchanged.
- R3: `full_n_o` is 0 in every cycle where the queue holds at least DEPTH-2 words.
- R4: Remote XOFF is registered once. In the cycle after `xoff_i` is sampled high, `full_n_o` is 0 and no word is drained, whatever the queue level.
- R5: Once `full_n_o` is 0, exactly two more writes are accepted. Further writes while it stays 0 are dropped. The slack allowance restarts in any cycle where `full_n_o` is 1.
- R6: A dropped write that exceeds the slack sets `ovf_err_o`. The bit stays at 1 until reset.
- R7: While `link_up_i` is 0, writes are ignored: they are not stored, they take no slack and they do not set `ovf_err_o`. No word is drained.
- R8: A word is drained in a cycle exactly when `drain_rdy_i` is 1, the link is up, XOFF is not in effect and the queue is not empty. `word_taken_o` is then 1, with the head word on `rd_data_o`/`rd_ctrl_o`. Control and data words each take one slot.
- R9: `xoff_led_o` equals the inverse of `full_n_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Word to queue |
| wr_ctrl_i | input | 1 | 1 = control word, 0 = data word |
| link_up_i | input | 1 | Link status, 1 = up |
| xoff_i | input | 1 | Pause request from the far end |
| drain_rdy_i | input | 1 | Serializer slot pulse |
| rd_data_o | output | 32 | Head word data |
| rd_ctrl_o | output | 1 | Head word control flag |
| word_taken_o | output | 1 | Head word handed to the serializer this cycle |
| full_n_o | output | 1 | Full flag, active low |
| xoff_led_o | output | 1 | Indicator drive, high while full |
| ovf_err_o | output | 1 | Sticky overflow error |

## Verification
A wrong occupancy count shows at the ports within one cycle. The full flag drops at the wrong level, or a drain slot is granted with nothing behind it, and the bench model catches the mismatch on `full_n_o` or `word_taken_o`. A corrupted slack counter drops or keeps the wrong write. The next drained words or `ovf_err_o` then differ from the model, as soon as the queue reaches that entry. A corrupted read pointer or storage entry surfaces on the first drain of the affected slot as a wrong data or control bit.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int unsigned LSB_DATA_W = 32;

  typedef struct packed {
    logic                  ctrl;
    logic [LSB_DATA_W-1:0] data;
  } lsb_word_t;
endpackage

// File: rtl/lsb_fifo.sv
module lsb_fifo
  import lsb_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  lsb_word_t                  push_word_i,
  input  logic                       pop_i,
  output lsb_word_t                  head_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       empty_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  lsb_word_t       mem_q [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= push_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = mem_q[rp_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q < FULL_CNT)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R8
endmodule

// File: rtl/lsb_flow.sv
module lsb_flow #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SLACK = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic                       link_up_i,
  input  logic                       xoff_i,
  input  logic                       drain_rdy_i,
  input  logic [$clog2(DEPTH+1)-1:0] count_i,
  input  logic                       empty_i,
  output logic                       push_o,
  output logic                       pop_o,
  output logic                       full_n_o,
  output logic                       ovf_o
);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam int unsigned SW = $clog2(SLACK+1);
  localparam logic [CW-1:0] THRESH = CW'(DEPTH - SLACK);
  localparam logic [SW-1:0] SLACK_L = SW'(SLACK);

  logic          xoff_q, ovf_q, full, room, drop;
  logic [SW-1:0] slack_q;

  assign full     = (count_i >= THRESH) || xoff_q;
  assign room     = !full || (slack_q < SLACK_L);
  assign push_o   = wr_en_i && link_up_i && room;
  assign drop     = wr_en_i && link_up_i && !room;
  assign pop_o    = drain_rdy_i && link_up_i && !xoff_q && !empty_i;
  assign full_n_o = !full;
  assign ovf_o    = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xoff_q  <= 1'b0;
      ovf_q   <= 1'b0;
      slack_q <= '0;
    end else begin
      xoff_q <= xoff_i;
      if (drop) ovf_q <= 1'b1;
      // slack restarts whenever the flag is seen high
      if (!full)       slack_q <= '0;
      else if (push_o) slack_q <= slack_q + 1'b1;
    end
  end

  AST_DOWN_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_up_i |-> (!push_o && !pop_o)); // R7
  AST_XOFF_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xoff_q |-> (!full_n_o && !pop_o)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R6
  AST_THRESH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i >= THRESH) |-> !full_n_o); // R3
endmodule

// File: rtl/lsb_write_buffer.sv
module lsb_write_buffer
  import lsb_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SLACK = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [LSB_DATA_W-1:0] wr_data_i,
  input  logic                  wr_ctrl_i,
  input  logic                  link_up_i,
  input  logic                  xoff_i,
  input  logic                  drain_rdy_i,
  output logic [LSB_DATA_W-1:0] rd_data_o,
  output logic                  rd_ctrl_o,
  output logic                  word_taken_o,
  output logic                  full_n_o,
  output logic                  xoff_led_o,
  output logic                  ovf_err_o
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  lsb_word_t     in_word, head;
  logic          push, pop, empty;
  logic [CW-1:0] count;

  assign in_word = '{ctrl: wr_ctrl_i, data: wr_data_i};

  lsb_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_word_i (in_word),
    .pop_i       (pop),
    .head_o      (head),
    .count_o     (count),
    .empty_o     (empty)
  );

  lsb_flow #(.DEPTH(DEPTH), .SLACK(SLACK)) i_flow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .link_up_i   (link_up_i),
    .xoff_i      (xoff_i),
    .drain_rdy_i (drain_rdy_i),
    .count_i     (count),
    .empty_i     (empty),
    .push_o      (push),
    .pop_o       (pop),
    .full_n_o    (full_n_o),
    .ovf_o       (ovf_err_o)
  );

  assign rd_data_o    = head.data;
  assign rd_ctrl_o    = head.ctrl;
  assign word_taken_o = pop;
  assign xoff_led_o   = !full_n_o;

  AST_TAKEN_NEEDS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_taken_o |-> (drain_rdy_i && link_up_i)); // R8
endmodule

// File: tb/test_lsb_write_buffer.sv
module test_lsb_write_buffer;
  localparam int DEPTH = 16;
  localparam int THR   = DEPTH - 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, wr_ctrl = 1'b0, link_up = 1'b0, xoff = 1'b0, rdy = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_ctrl, taken, full_n, led, ovf;

  int vectors = 0;
  int errors  = 0;

  // bench model
  logic [32:0] mq [DEPTH];
  int m_cnt, m_rp, m_wp, m_sl;
  logic m_xq, m_ovf;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  lsb_write_buffer #(.DEPTH(DEPTH), .SLACK(2)) i_lsb_write_buffer (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_ctrl_i(wr_ctrl), .link_up_i(link_up), .xoff_i(xoff), .drain_rdy_i(rdy),
    .rd_data_o(rd_data), .rd_ctrl_o(rd_ctrl), .word_taken_o(taken),
    .full_n_o(full_n), .xoff_led_o(led), .ovf_err_o(ovf)
  );

  function automatic logic [31:0] nxt(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  task automatic cmp(input string req, input string what, input logic [32:0] act, input logic [32:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_rp = 0; m_wp = 0; m_sl = 0; m_xq = 1'b0; m_ovf = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; wr_en = 0; xoff = 0; rdy = 0; link_up = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
    #1;
    cmp("R1", "full_n", {32'd0, full_n}, 33'd1);
    cmp("R1", "led", {32'd0, led}, 33'd0);
    cmp("R1", "taken", {32'd0, taken}, 33'd0);
    cmp("R1", "ovf", {32'd0, ovf}, 33'd0);
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic c,
                      input logic up, input logic xo, input logic r);
    logic e_full, e_push, e_pop, e_drop;
    @(negedge clk);
    wr_en = w; wr_data = d; wr_ctrl = c; link_up = up; xoff = xo; rdy = r;
    #1;
    e_full = (m_cnt >= THR) || m_xq;
    e_push = w && up && (!e_full || m_sl < 2);
    e_drop = w && up && e_full && m_sl >= 2;
    e_pop  = r && up && !m_xq && (m_cnt > 0);
    cmp(m_xq ? "R4" : "R3", "full_n", {32'd0, full_n}, {32'd0, !e_full});
    cmp("R9", "led", {32'd0, led}, {32'd0, e_full});
    cmp(up ? "R8" : "R7", "taken", {32'd0, taken}, {32'd0, e_pop});
    if (e_pop) cmp("R2", "head", {rd_ctrl, rd_data}, mq[m_rp]);
    cmp("R6", "ovf", {32'd0, ovf}, {32'd0, m_ovf});
    // model update, mirrors the upcoming edge
    if (e_pop) begin m_rp = (m_rp + 1) % DEPTH; m_cnt--; end
    if (e_push) begin mq[m_wp] = {c, d}; m_wp = (m_wp + 1) % DEPTH; m_cnt++; end
    m_sl  = e_full ? m_sl + (e_push ? 1 : 0) : 0;
    if (e_drop) m_ovf = 1'b1;
    m_xq = xo;
  endtask

  // watchdog
  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R5 R6: fill with no drain, exactly DEPTH accepted, then overflow
    for (int i = 0; i < DEPTH + 4; i++) begin
      lfsr = nxt(lfsr);
      step(1, lfsr, lfsr[3], 1, 0, 0);
    end
    // R7: writes while down are ignored and do not raise overflow beyond sticky
    for (int i = 0; i < 4; i++) step(1, 32'hDEAD_0000 + i, 0, 0, 0, 1);
    // R2 R8: drain everything in order
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1, 0, 1);
    // R6: sticky after queue emptied
    step(0, 0, 0, 1, 0, 0);

    // R7: down writes on a fresh reset leave ovf clear and queue empty
    do_reset();
    for (int i = 0; i < 8; i++) step(1, 32'hBAD0_0000 + i, 1, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 1);

    // R4: xoff at low level, full drops, only two slack writes
    do_reset();
    step(1, 32'h1111_1111, 0, 1, 1, 1);
    for (int i = 0; i < 5; i++) step(1, 32'h2222_0000 + i, 1, 1, 1, 1);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 0, 1);

    // near-exhaustive sweep: drain period, xoff and link patterns
    for (int per = 1; per <= 4; per++) begin
      for (int pat = 0; pat < 4; pat++) begin
        do_reset();
        for (int cyc = 0; cyc < 400; cyc++) begin
          logic w, up, xo, r;
          lfsr = nxt(lfsr);
          w  = (pat[0]) ? lfsr[0] | lfsr[5] : 1'b1;
          xo = pat[1] && (cyc % 37 < 6);
          up = !(pat == 3 && (cyc % 91 < 7));
          r  = (cyc % per) == 0;
          // back off writes when flag is low, as a well-behaved writer would
          if (pat == 2 && !full_n) w = lfsr[9];
          step(w, nxt(lfsr), lfsr[7] & lfsr[2], up, xo, r);
        end
        for (int cyc = 0; cyc < DEPTH + 2; cyc++) step(0, 0, 0, 1, 0, 1);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule